// File: doc/BRIEF.md
# I/O translation unit control register bank

This block is the software-visible register file of an I/O address translation unit. A bus master reads and writes it one 32-bit word at a time. The bank stores the translation window size and enable, the page-table base, two flush registers, the fault status and fault address, the arbiter enable, one configuration word per slot, the arbitration enable and a sticky identification word. Every register has its own set of writable bits and its own bits that are always one.

The bank feeds the translation engine through three ports: the enable, the page-table base, and the base address of the window that ends at 0xFFFFFFFF. The window base is decoded from the 3-bit range code on every control write. The engine reports translation faults back through a capture port. A capture loads the fault registers and raises the fault interrupt. Any software access to either fault register lowers the interrupt.

Reads return data one cycle after the request, flagged by `rvalid_o`.

Top module: `iotu_regbank`

## Requirements
- R1: After reset the registers read as follows. Control is VERSION<<24 (0x41000000 by default). Arbitration enable (0x2000) is 0x00000008. Fault status (0x1000) is 0x00800000. Arbiter enable (0x1008) is 0x00000003. Mask id (0x3018) is 0x23000000. All other registers are 0. `win_base_o` is 0 and `irq_o` and `xlat_en_o` are low.
- R2: A control write (offset 0x0000) keeps only the bits under 0x0000001D. Bit 0 is the enable and drives `xlat_en_o`; bits 4:2 are the range code. Bits 31:24 always read back as VERSION.
- R3: On every control write, `win_base_o` becomes 0xFFFFFFFF shifted left by (24 + range code). The codes 0..7 therefore give 0xFF000000 up to 0x80000000, for window sizes from 16MB to 2GB.
- R4: A table base write (0x0004) keeps the bits under 0x07FFFC00, and `tbl_base_o` shows the stored value. The full flush (0x0014) and page flush (0x0018) registers store all 32 bits written.
- R5: A fault status write (0x1000) keeps the bits under 0xFF0FFFFF and forces bit 23 to one.
- R6: A fault address write (0x1004) stores the value unmasked. Any word read or write of 0x1000 or 0x1004 lowers `irq_o` in the following cycle.
- R7: An arbiter enable write (0x1008) keeps the bits under 0x801F000F and forces bit 0 to one.
- R8: A write to a slot configuration register (0x1010 + 4*slot, slots 0..3) keeps the bits under 0x00010003. An arbitration enable write (0x2000) keeps the bits under 0x001F0000 and forces 0x00000008.
- R9: A mask id write (0x3018) ORs the written bits 23:0 into the stored value. Software cannot clear any bit, and bits 31:24 are not writable.
- R10: A fault capture (`flt_cap_i`) sets fault status to 0xC0820000, or to 0xC0860000 when `flt_rd_i` is high. It loads the fault address with `flt_addr_i`, and `irq_o` is high from the next cycle.
- R11: When a capture and a software access to the fault registers fall in the same cycle, the capture wins. Both fault registers take the captured values and `irq_o` stays high.
- R12: Reads of unimplemented or unaligned offsets return 0, and writes to them change nothing. An access with `word_i` low writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | Access is a full 32-bit word |
| addr_i | input | 14 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| flt_cap_i | input | 1 | Fault capture strobe from the translation engine |
| flt_addr_i | input | 32 | Faulting page address |
| flt_rd_i | input | 1 | Faulting access was a read |
| irq_o | output | 1 | Fault interrupt |
| xlat_en_o | output | 1 | Translation enable |
| win_base_o | output | 32 | Decoded translation window base |
| tbl_base_o | output | 32 | Page-table base register |

## Verification
Each register is written with all ones and then with all zeros. This shows its keep mask apart from its forced bits. The window decode is exercised for the smallest, largest and an interior range code, so a wrong shift or an off-by-one code shows up. The capture is tried alone and then coincident with a fault status write, a fault address write and a fault read, which tells hardware priority apart from software priority. The mask id is given disjoint bit patterns and a zero write, and unmapped, unaligned and non-word accesses are issued against a register that holds a known value.

// File: rtl/iotu_pkg.sv
package iotu_pkg;
  localparam int DATA_W = 32;

  localparam logic [13:0] OFS_CTRL = 14'h0000;
  localparam logic [13:0] OFS_TBL  = 14'h0004;
  localparam logic [13:0] OFS_FLA  = 14'h0014;
  localparam logic [13:0] OFS_FLP  = 14'h0018;
  localparam logic [13:0] OFS_AFSR = 14'h1000;
  localparam logic [13:0] OFS_AFAR = 14'h1004;
  localparam logic [13:0] OFS_AER  = 14'h1008;
  localparam logic [13:0] OFS_SLOT = 14'h1010;
  localparam logic [13:0] OFS_ARB  = 14'h2000;
  localparam logic [13:0] OFS_MID  = 14'h3018;

  localparam logic [31:0] KEEP_CTRL = 32'h0000_001D;
  localparam logic [31:0] KEEP_TBL  = 32'h07FF_FC00;
  localparam logic [31:0] KEEP_AFSR = 32'hFF0F_FFFF;
  localparam logic [31:0] ONE_AFSR  = 32'h0080_0000;
  localparam logic [31:0] KEEP_AER  = 32'h801F_000F;
  localparam logic [31:0] ONE_AER   = 32'h0000_0001;
  localparam logic [31:0] KEEP_SLOT = 32'h0001_0003;
  localparam logic [31:0] KEEP_ARB  = 32'h001F_0000;
  localparam logic [31:0] ONE_ARB   = 32'h0000_0008;
  localparam logic [31:0] KEEP_MID  = 32'h00FF_FFFF;

  localparam logic [31:0] RST_AER = 32'h0000_0003;
  localparam logic [31:0] RST_MID = 32'h2300_0000;

  // capture status: error, late error, reserved one, address valid; plus read
  localparam logic [31:0] CAP_AFSR = 32'hC082_0000;
  localparam logic [31:0] CAP_RD   = 32'h0004_0000;

  typedef enum logic [3:0] {
    RID_NONE, RID_CTRL, RID_TBL, RID_FLA, RID_FLP, RID_AFSR,
    RID_AFAR, RID_AER, RID_SLOT, RID_ARB, RID_MID
  } rid_e;
endpackage

// File: rtl/iotu_decode.sv
module iotu_decode
  import iotu_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rid_e              rid_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [13:0] a;
  assign a = 14'(addr_i);

  always_comb begin
    rid_o  = RID_NONE;
    slot_o = '0;
    unique case (a)
      OFS_CTRL: rid_o = RID_CTRL;
      OFS_TBL:  rid_o = RID_TBL;
      OFS_FLA:  rid_o = RID_FLA;
      OFS_FLP:  rid_o = RID_FLP;
      OFS_AFSR: rid_o = RID_AFSR;
      OFS_AFAR: rid_o = RID_AFAR;
      OFS_AER:  rid_o = RID_AER;
      OFS_ARB:  rid_o = RID_ARB;
      OFS_MID:  rid_o = RID_MID;
      default: begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (a == OFS_SLOT + 14'(4 * i)) begin
            rid_o  = RID_SLOT;
            slot_o = SLOT_W'(i);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/iotu_win_dec.sv
module iotu_win_dec #(
  parameter int CODE_W = 3,
  parameter int MIN_LG = 24
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [31:0]       base_o
);
  assign base_o = 32'hFFFF_FFFF << (MIN_LG + int'(code_i));
endmodule

// File: rtl/iotu_fault.sv
module iotu_fault
  import iotu_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_afsr_i,
  input  logic        we_afar_i,
  input  logic        touch_i,
  input  logic [31:0] wdata_i,
  input  logic        cap_i,
  input  logic [31:0] cap_addr_i,
  input  logic        cap_rd_i,
  output logic [31:0] afsr_o,
  output logic [31:0] afar_o,
  output logic        irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      afsr_o <= ONE_AFSR;
      afar_o <= '0;
      irq_o  <= 1'b0;
    end else if (cap_i) begin
      // hardware capture overrides any same-cycle software access
      afsr_o <= CAP_AFSR | (cap_rd_i ? CAP_RD : 32'h0);
      afar_o <= cap_addr_i;
      irq_o  <= 1'b1;
    end else begin
      if (we_afsr_i) afsr_o <= (wdata_i & KEEP_AFSR) | ONE_AFSR;
      if (we_afar_i) afar_o <= wdata_i;
      if (touch_i)   irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/iotu_regbank.sv
module iotu_regbank
  import iotu_pkg::*;
#(
  parameter logic [7:0] VERSION   = 8'h41,
  parameter int         ADDR_W    = 14,
  parameter int         NUM_SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              flt_cap_i,
  input  logic [31:0]       flt_addr_i,
  input  logic              flt_rd_i,
  output logic              irq_o,
  output logic              xlat_en_o,
  output logic [31:0]       win_base_o,
  output logic [31:0]       tbl_base_o
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  rid_e              rid;
  logic [SLOT_W-1:0] slot;
  logic              acc, wr;
  logic [4:0]        ctrl_q;
  logic [31:0]       tbl_q, fla_q, flp_q, aer_q, arb_q, mid_q, win_q;
  logic [31:0]       afsr_q, afar_q, win_nxt, rd_val;
  logic [31:0]       slot_q [NUM_SLOTS];

  assign acc = req_i & word_i;
  assign wr  = acc & we_i;

  iotu_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr_i(addr_i), .rid_o(rid), .slot_o(slot)
  );

  iotu_win_dec #(.CODE_W(3), .MIN_LG(24)) u_win (
    .code_i(wdata_i[4:2]), .base_o(win_nxt)
  );

  iotu_fault u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_afsr_i(wr && rid == RID_AFSR),
    .we_afar_i(wr && rid == RID_AFAR),
    .touch_i(acc && (rid == RID_AFSR || rid == RID_AFAR)),
    .wdata_i(wdata_i),
    .cap_i(flt_cap_i), .cap_addr_i(flt_addr_i), .cap_rd_i(flt_rd_i),
    .afsr_o(afsr_q), .afar_o(afar_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      win_q  <= '0;
      tbl_q  <= '0;
      fla_q  <= '0;
      flp_q  <= '0;
      aer_q  <= RST_AER;
      arb_q  <= ONE_ARB;
      mid_q  <= RST_MID;
    end else if (wr) begin
      unique case (rid)
        RID_CTRL: begin
          ctrl_q <= wdata_i[4:0] & KEEP_CTRL[4:0];
          win_q  <= win_nxt;
        end
        RID_TBL: tbl_q <= wdata_i & KEEP_TBL;
        RID_FLA: fla_q <= wdata_i;
        RID_FLP: flp_q <= wdata_i;
        RID_AER: aer_q <= (wdata_i & KEEP_AER) | ONE_AER;
        RID_ARB: arb_q <= (wdata_i & KEEP_ARB) | ONE_ARB;
        RID_MID: mid_q <= mid_q | (wdata_i & KEEP_MID);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     slot_q[g] <= '0;
      else if (wr && rid == RID_SLOT && slot == SLOT_W'(g)) slot_q[g] <= wdata_i & KEEP_SLOT;
    end
  end

  always_comb begin
    unique case (rid)
      RID_CTRL: rd_val = {VERSION, 19'b0, ctrl_q};
      RID_TBL:  rd_val = tbl_q;
      RID_FLA:  rd_val = fla_q;
      RID_FLP:  rd_val = flp_q;
      RID_AFSR: rd_val = afsr_q;
      RID_AFAR: rd_val = afar_q;
      RID_AER:  rd_val = aer_q;
      RID_SLOT: rd_val = slot_q[slot];
      RID_ARB:  rd_val = arb_q;
      RID_MID:  rd_val = mid_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i & ~we_i) rdata_o <= word_i ? rd_val : 32'h0;
    end
  end

  assign xlat_en_o  = ctrl_q[0];
  assign win_base_o = win_q;
  assign tbl_base_o = tbl_q;
endmodule

// File: rtl/iotu_regbank_chk.sv
module iotu_regbank_chk
  import iotu_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              word_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              flt_cap_i,
  input logic [31:0]       flt_addr_i,
  input logic              irq_o,
  input logic [31:0]       win_base_o,
  input logic [31:0]       tbl_base_o,
  input logic [31:0]       afsr_q,
  input logic [31:0]       afar_q,
  input logic [31:0]       aer_q,
  input logic [31:0]       mid_q
);
  logic flt_touch;
  assign flt_touch = req_i && word_i &&
                     (14'(addr_i) == OFS_AFSR || 14'(addr_i) == OFS_AFAR);

  a_r5_resv_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    afsr_q[23]);

  a_r10_cap_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_cap_i |=> irq_o && afar_q == $past(flt_addr_i));

  // R11: capture wins over a same-cycle software touch
  a_r11_cap_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_cap_i && flt_touch) |=> irq_o);

  a_r6_access_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_touch && !flt_cap_i) |=> !irq_o);

  a_r3_win_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_base_o[23:0] == 24'h0);

  a_r4_tbl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_base_o & ~KEEP_TBL) == 32'h0);

  a_r7_aer_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aer_q[0]);

  a_r9_mid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_q & $past(mid_q)) == $past(mid_q));
endmodule

bind iotu_regbank iotu_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/iotu_regbank_tb_top.sv
module iotu_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0, word = 1;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        cap = 0, cap_rd = 0;
  logic [31:0] cap_addr = '0;
  logic        irq, xen;
  logic [31:0] win, tbl;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 0;

  always #2 clk = ~clk;

  iotu_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .flt_cap_i(cap), .flt_addr_i(cap_addr), .flt_rd_i(cap_rd),
    .irq_o(irq), .xlat_en_o(xen), .win_base_o(win), .tbl_base_o(tbl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop the expected read data when the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("unexpected read", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] e, input string tag);
    req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 xlat_en", {31'b0, xen}, 0);
    check("R1 win_base", win, 0);
    rd(14'h0000, 32'h4100_0000, "R1 ctrl");
    rd(14'h2000, 32'h0000_0008, "R1 arben");
    rd(14'h1000, 32'h0080_0000, "R1 afsr");
    rd(14'h1008, 32'h0000_0003, "R1 aer");
    rd(14'h3018, 32'h2300_0000, "R1 mid");
    rd(14'h0004, 32'h0, "R1 tbl");
    rd(14'h1014, 32'h0, "R1 slot1");

    // R2 / R3 control and window decode
    wr(14'h0000, 32'hFFFF_FFFF);
    check("R3 win code7", win, 32'h8000_0000);
    check("R2 xlat_en", {31'b0, xen}, 1);
    rd(14'h0000, 32'h4100_001D, "R2 ctrl all ones");
    wr(14'h0000, 32'h0000_0000);
    check("R3 win code0", win, 32'hFF00_0000);
    check("R2 xlat_en off", {31'b0, xen}, 0);
    rd(14'h0000, 32'h4100_0000, "R2 ctrl zeros");
    wr(14'h0000, 32'h0000_0009);
    check("R3 win code2", win, 32'hFC00_0000);
    rd(14'h0000, 32'h4100_0009, "R2 ctrl code2");
    wr(14'h0000, 32'h0000_0014);
    check("R3 win code5", win, 32'hE000_0000);

    // R4 table base and flushes
    wr(14'h0004, 32'hFFFF_FFFF);
    check("R4 tbl_base_o", tbl, 32'h07FF_FC00);
    rd(14'h0004, 32'h07FF_FC00, "R4 tbl");
    wr(14'h0014, 32'hDEAD_BEEF);
    wr(14'h0018, 32'h1234_5678);
    rd(14'h0014, 32'hDEAD_BEEF, "R4 full flush");
    rd(14'h0018, 32'h1234_5678, "R4 page flush");

    // R5 fault status
    wr(14'h1000, 32'hFFFF_FFFF);
    rd(14'h1000, 32'hFF8F_FFFF, "R5 afsr ones");
    wr(14'h1000, 32'h0);
    rd(14'h1000, 32'h0080_0000, "R5 afsr zeros");

    // R7 arbiter enable
    wr(14'h1008, 32'hFFFF_FFFF);
    rd(14'h1008, 32'h801F_000F, "R7 aer ones");
    wr(14'h1008, 32'h0);
    rd(14'h1008, 32'h0000_0001, "R7 aer zeros");

    // R8 slot configs and arbitration enable
    for (int i = 0; i < 4; i++) wr(14'h1010 + 14'(4 * i), 32'hFFFF_FFFF);
    wr(14'h1018, 32'h0);
    rd(14'h1010, 32'h0001_0003, "R8 slot0");
    rd(14'h1018, 32'h0, "R8 slot2 cleared");
    rd(14'h101C, 32'h0001_0003, "R8 slot3");
    wr(14'h2000, 32'hFFFF_FFFF);
    rd(14'h2000, 32'h001F_0008, "R8 arben ones");
    wr(14'h2000, 32'h0);
    rd(14'h2000, 32'h0000_0008, "R8 arben zeros");

    // R9 mask id sticky OR
    wr(14'h3018, 32'h0000_0F0F);
    rd(14'h3018, 32'h2300_0F0F, "R9 mid first");
    wr(14'h3018, 32'hFFF0_0000);
    rd(14'h3018, 32'h23F0_0F0F, "R9 mid or");
    wr(14'h3018, 32'h0);
    rd(14'h3018, 32'h23F0_0F0F, "R9 mid zero write");

    // R10 capture (write access) and R6 clear by read
    cap = 1; cap_addr = 32'hABCD_E000; cap_rd = 0;
    idle();
    cap = 0;
    check("R10 irq raised", {31'b0, irq}, 1);
    rd(14'h1000, 32'hC082_0000, "R10 afsr write fault");
    check("R6 irq cleared by read", {31'b0, irq}, 0);
    rd(14'h1004, 32'hABCD_E000, "R10 afar");

    // R6 fault address write unmasked and clears irq
    cap = 1; cap_addr = 32'h0000_1000; cap_rd = 1;
    idle();
    cap = 0;
    check("R10 irq raised again", {31'b0, irq}, 1);
    rd(14'h1000, 32'hC086_0000, "R10 afsr read fault");
    cap = 1; idle(); cap = 0;
    wr(14'h1004, 32'hFFFF_FFFF);
    check("R6 irq cleared by afar write", {31'b0, irq}, 0);
    rd(14'h1004, 32'hFFFF_FFFF, "R6 afar unmasked");

    // R11 capture beats same-cycle software write
    cap = 1; cap_addr = 32'h5555_5000; cap_rd = 1;
    wr(14'h1000, 32'h0);
    cap = 0;
    check("R11 irq kept on afsr write", {31'b0, irq}, 1);
    rd(14'h1000, 32'hC086_0000, "R11 afsr capture wins");
    cap = 1; cap_addr = 32'h7777_7000; cap_rd = 0;
    wr(14'h1004, 32'h1111_1111);
    cap = 0;
    rd(14'h1004, 32'h7777_7000, "R11 afar capture wins");
    cap = 1; cap_addr = 32'h8888_8000;
    rd(14'h1000, 32'h0080_0000 | 32'hC002_0000, "R11 read during capture");
    cap = 0;
    check("R11 irq kept on read", {31'b0, irq}, 1);

    // R12 unimplemented, unaligned and non-word accesses
    wr(14'h0008, 32'hFFFF_FFFF);
    rd(14'h0008, 32'h0, "R12 unimpl read");
    rd(14'h3FFC, 32'h0, "R12 far unimpl read");
    rd(14'h0006, 32'h0, "R12 unaligned read");
    wr(14'h0005, 32'h0);
    word = 0;
    wr(14'h0004, 32'h0);
    rd(14'h0004, 32'h0, "R12 non-word read");
    word = 1;
    check("R12 tbl unchanged", tbl, 32'h07FF_FC00);
    rd(14'h0004, 32'h07FF_FC00, "R12 tbl after ignored writes");
    rd(14'h0014, 32'hDEAD_BEEF, "R12 flush untouched");

    repeat (3) idle();
    if (exp_q.size() != 0) check("R12 reads outstanding", 32'(exp_q.size()), 0);
    finish_up();
  end
endmodule